// File: doc/BRIEF.md
# USB On-the-Go Interrupt Status and Bus Configuration Registers

This block is a small register slice inside a USB on-the-go controller. A simple word-wide bus port with a register select, a write strobe and a same-cycle read path gives access to two registers. The first is an interrupt status register. It holds a session-end flag that only hardware can set: the flag goes high when the Bvalid/Vbus indication from the transceiver is lost. Software clears it by writing a 1. The second is a configuration register. It holds a global interrupt enable and two threshold selects. Each select decides whether a transmit-FIFO empty interrupt fires at half empty or only when the FIFO is fully empty.

The periodic threshold applies in host mode only. The other threshold applies to the non-periodic transmit FIFO in host mode and to the IN-endpoint transmit FIFO in device mode. Fill counts come from the FIFOs outside the block, and the block reports both empty flags as live levels. The session-end flag and the empty flags are combined, gated by the global enable, and registered into one interrupt line. Bvalid passes through a two-flop synchronizer. A two-state tracker then watches the synchronized level. Its states are `VB_ABSENT` and `VB_PRESENT`. The transition `VB_ABSENT -> VB_PRESENT` happens when the synchronized Bvalid is seen high. The transition `VB_PRESENT -> VB_ABSENT` happens when it is seen low, and that transition emits the one-cycle session-end set pulse.

Top module: `otg_irq_regs`

## Requirements
- R1: After reset both registers read 0 and `irq_out` is 0.
- R2: A high-to-low change of `vbus_valid` sets the session-end flag (status bit 2) in either mode. The flag reads 1 on the third rising clock edge after the change and not before. A low-to-high change never sets it.
- R3: A write to the status register (`reg_sel`=0) with bit 2 at 1 clears the session-end flag. A 0 in bit 2 leaves it unchanged, and software writes can never set it.
- R4: When a hardware set and a software clear of the session-end flag fall in the same cycle, the flag ends up 1.
- R5: `ptx_empty` is 0 in device mode (`host_mode`=0). In host mode, with configuration bit 8 at 0 it is 1 when `ptx_fill` <= DEPTH/2 (free space at least half the depth). With bit 8 at 1 it is 1 only when `ptx_fill` is 0.
- R6: `np_empty` follows the same rule under configuration bit 7 (0 = half empty, 1 = fully empty). It compares `nptx_fill` in host mode and `inep_fill` in device mode.
- R7: `irq_out` equals the OR of the session-end flag, `ptx_empty` and `np_empty`, ANDed with configuration bit 0, delayed by one clock.
- R8: The configuration register (`reg_sel`=1) stores only bits 8, 7 and 0. The status register holds only bit 2. All other bits read 0 and ignore writes.
- R9: The configuration register changes only on a write strobe with `reg_sel`=1. Status writes leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 configuration |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the selected register, same cycle |
| vbus_valid | input | 1 | Asynchronous Bvalid/Vbus indication |
| host_mode | input | 1 | 1 host mode, 0 device mode |
| ptx_fill | input | FILL_W | Periodic transmit FIFO fill count |
| nptx_fill | input | FILL_W | Non-periodic transmit FIFO fill count (host) |
| inep_fill | input | FILL_W | IN-endpoint transmit FIFO fill count (device) |
| ptx_empty | output | 1 | Periodic FIFO empty-threshold flag |
| np_empty | output | 1 | Non-periodic / IN-endpoint FIFO empty-threshold flag |
| irq_out | output | 1 | Registered, globally gated interrupt line |

## Verification
Two events can fall in the same cycle: the hardware session-end set, produced by the synchronized loss of Bvalid, and a software write-one clear of the same flag. The bench drops `vbus_valid` and counts the synchronizer stages. It then holds a clearing status write across exactly the clock edge on which the set lands, and requires the flag to read back as 1. A clear one cycle later must then succeed. The threshold selection across modes is walked through a vector table that also checks the registered interrupt line.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;

    // Field positions decoded by software.
    localparam int SESS_END_BIT = 2;
    localparam int PTX_LVL_BIT  = 8;
    localparam int NP_LVL_BIT   = 7;
    localparam int GMASK_BIT    = 0;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CONFIG = 1'b1
    } reg_sel_e;

    typedef enum logic {
        VB_ABSENT  = 1'b0,
        VB_PRESENT = 1'b1
    } vbus_state_e;

    typedef struct packed {
        logic ptx_full_lvl;
        logic np_full_lvl;
        logic gmask;
    } cfg_t;

endpackage

// File: rtl/otg_vbus_track.sv
module otg_vbus_track
    import otg_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vbus_async,
    output logic vbus_sync,
    output logic sess_set
);

    logic [SYNC_STAGES-1:0] sync_q;
    vbus_state_e            state_q;
    vbus_state_e            state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], vbus_async};
        end
    end

    assign vbus_sync = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VB_ABSENT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VB_ABSENT:  if (vbus_sync)  state_d = VB_PRESENT;
            VB_PRESENT: if (!vbus_sync) state_d = VB_ABSENT;
            default:    state_d = VB_ABSENT;
        endcase
    end

    // Outputs
    always_comb begin
        sess_set = 1'b0;
        unique case (state_q)
            VB_ABSENT:  sess_set = 1'b0;
            VB_PRESENT: sess_set = !vbus_sync;
            default:    sess_set = 1'b0;
        endcase
    end

endmodule

// File: rtl/otg_fifo_thresh.sv
module otg_fifo_thresh #(
    parameter  int DEPTH  = 16,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic [FILL_W-1:0] fill,
    input  logic              full_lvl,
    input  logic              active,
    output logic              empty_flag
);

    // Free space >= DEPTH/2  <=>  fill <= DEPTH - DEPTH/2
    localparam logic [FILL_W-1:0] HALF_LIMIT = FILL_W'(DEPTH - DEPTH / 2);

    logic half_met;
    logic full_met;

    assign half_met   = (fill <= HALF_LIMIT);
    assign full_met   = (fill == '0);
    assign empty_flag = active && (full_lvl ? full_met : half_met);

endmodule

// File: rtl/otg_irq_regfile.sv
module otg_irq_regfile
    import otg_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sess_set,
    input  logic              ptx_flag,
    input  logic              np_flag,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg_q,
    output logic              sess_end_q,
    output logic              irq_q
);

    logic sess_clr;
    logic cfg_we;
    logic irq_d;

    assign sess_clr = wr_en && (reg_sel == SEL_STATUS) && wr_data[SESS_END_BIT];
    assign cfg_we   = wr_en && (reg_sel == SEL_CONFIG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sess_end_q <= 1'b0;
        end else if (sess_set) begin
            sess_end_q <= 1'b1;
        end else if (sess_clr) begin
            sess_end_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.ptx_full_lvl <= wr_data[PTX_LVL_BIT];
            cfg_q.np_full_lvl  <= wr_data[NP_LVL_BIT];
            cfg_q.gmask        <= wr_data[GMASK_BIT];
        end
    end

    assign irq_d = cfg_q.gmask && (sess_end_q || ptx_flag || np_flag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel)
            SEL_STATUS: rd_data[SESS_END_BIT] = sess_end_q;
            SEL_CONFIG: begin
                rd_data[PTX_LVL_BIT] = cfg_q.ptx_full_lvl;
                rd_data[NP_LVL_BIT]  = cfg_q.np_full_lvl;
                rd_data[GMASK_BIT]   = cfg_q.gmask;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/otg_irq_regs.sv
module otg_irq_regs
    import otg_irq_pkg::*;
#(
    parameter  int DATA_W      = 32,
    parameter  int FIFO_DEPTH  = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int FILL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              vbus_valid,
    input  logic              host_mode,
    input  logic [FILL_W-1:0] ptx_fill,
    input  logic [FILL_W-1:0] nptx_fill,
    input  logic [FILL_W-1:0] inep_fill,
    output logic              ptx_empty,
    output logic              np_empty,
    output logic              irq_out
);

    localparam int N_CH = 2;
    localparam int CH_P = 0;
    localparam int CH_N = 1;

    logic              sess_set;
    logic              vbus_sync;
    logic              sess_end_q;
    cfg_t              cfg_q;
    logic [FILL_W-1:0] ch_fill   [N_CH];
    logic [N_CH-1:0]   ch_lvl;
    logic [N_CH-1:0]   ch_active;
    logic [N_CH-1:0]   ch_flag;

    otg_vbus_track #(.SYNC_STAGES(SYNC_STAGES)) u_vbus (
        .clk        (clk),
        .rst_n      (rst_n),
        .vbus_async (vbus_valid),
        .vbus_sync  (vbus_sync),
        .sess_set   (sess_set)
    );

    // Per-channel routing: periodic is host-only, the other FIFO follows mode.
    assign ch_fill[CH_P]   = ptx_fill;
    assign ch_lvl[CH_P]    = cfg_q.ptx_full_lvl;
    assign ch_active[CH_P] = host_mode;
    assign ch_fill[CH_N]   = host_mode ? nptx_fill : inep_fill;
    assign ch_lvl[CH_N]    = cfg_q.np_full_lvl;
    assign ch_active[CH_N] = 1'b1;

    for (genvar g = 0; g < N_CH; g++) begin : g_thresh
        otg_fifo_thresh #(.DEPTH(FIFO_DEPTH)) u_thr (
            .fill       (ch_fill[g]),
            .full_lvl   (ch_lvl[g]),
            .active     (ch_active[g]),
            .empty_flag (ch_flag[g])
        );
    end

    assign ptx_empty = ch_flag[CH_P];
    assign np_empty  = ch_flag[CH_N];

    otg_irq_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wr_data    (wr_data),
        .sess_set   (sess_set),
        .ptx_flag   (ch_flag[CH_P]),
        .np_flag    (ch_flag[CH_N]),
        .rd_data    (rd_data),
        .cfg_q      (cfg_q),
        .sess_end_q (sess_end_q),
        .irq_q      (irq_out)
    );

endmodule

// File: rtl/otg_irq_regs_chk.sv
module otg_irq_regs_chk #(
    parameter int DATA_W = 32,
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              host_mode,
    input logic [FILL_W-1:0] ptx_fill,
    input logic [FILL_W-1:0] nptx_fill,
    input logic [FILL_W-1:0] inep_fill,
    input logic              ptx_empty,
    input logic              np_empty,
    input logic              irq_out,
    input logic              sess_set,
    input logic              sess_end_q,
    input logic [2:0]        cfg_bits
);

    logic clr_req;
    assign clr_req = wr_en && !reg_sel && wr_data[2];

    // R2 / R4: a hardware set always lands, even against a clear.
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sess_set |=> sess_end_q);

    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !sess_set) |=> !sess_end_q);

    a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!sess_set && !clr_req) |=> $stable(sess_end_q));

    a_r5_device_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> !ptx_empty);

    a_r5_full_lvl: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[2] && ptx_empty) |-> (ptx_fill == '0));

    a_r6_full_lvl: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[1] && np_empty) |-> ((host_mode ? nptx_fill : inep_fill) == '0));

    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bits[0] |=> !irq_out);

    a_r7_sess_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[0] && sess_end_q) |=> irq_out);

    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rd_data[DATA_W-1:9] == '0 && rd_data[6:1] == '0));

    a_r8_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> ($countones(rd_data) == (sess_end_q ? 1 : 0)));

endmodule

bind otg_irq_regs otg_irq_regs_chk #(.DATA_W(DATA_W), .FILL_W(FILL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .host_mode  (host_mode),
    .ptx_fill   (ptx_fill),
    .nptx_fill  (nptx_fill),
    .inep_fill  (inep_fill),
    .ptx_empty  (ptx_empty),
    .np_empty   (np_empty),
    .irq_out    (irq_out),
    .sess_set   (sess_set),
    .sess_end_q (sess_end_q),
    .cfg_bits   (cfg_q)
);

// File: tb/otg_irq_regs_bench.sv
module otg_irq_regs_bench;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int FW     = 5;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              reg_sel = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              vbus_valid = 1'b0;
    logic              host_mode = 1'b1;
    logic [FW-1:0]     ptx_fill = 5'd16;
    logic [FW-1:0]     nptx_fill = 5'd16;
    logic [FW-1:0]     inep_fill = 5'd16;
    logic              ptx_empty;
    logic              np_empty;
    logic              irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    otg_irq_regs #(.DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) u_otg_irq_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_sel    (reg_sel),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .vbus_valid (vbus_valid),
        .host_mode  (host_mode),
        .ptx_fill   (ptx_fill),
        .nptx_fill  (nptx_fill),
        .inep_fill  (inep_fill),
        .ptx_empty  (ptx_empty),
        .np_empty   (np_empty),
        .irq_out    (irq_out)
    );

    // {host, plvl, nlvl, ptx_fill, nptx_fill, inep_fill, exp_ptx, exp_np}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 5'd8,  5'd8,  5'd0,  1'b1, 1'b1},
        {1'b1, 1'b0, 1'b0, 5'd9,  5'd9,  5'd0,  1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 5'd0,  5'd1,  5'd0,  1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 5'd1,  5'd0,  5'd16, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 5'd0,  5'd16, 5'd4,  1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 5'd0,  5'd0,  5'd12, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b1, 5'd0,  5'd5,  5'd0,  1'b0, 1'b1},
        {1'b0, 1'b1, 1'b1, 5'd0,  5'd0,  5'd3,  1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 5'd16, 5'd0,  5'd0,  1'b0, 1'b1},
        {1'b1, 1'b1, 1'b0, 5'd0,  5'd12, 5'd0,  1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; write held across one rising edge.
    task automatic bus_write(input logic sel, input logic [31:0] d);
        reg_sel = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic bus_read(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1: reset state
        bus_read(1'b0, d); check("R1 status", d, 32'h0);
        bus_read(1'b1, d); check("R1 config", d, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // R5 R6 R7: threshold vector table, global enable on
        for (int i = 0; i < NVEC; i++) begin
            host_mode = VEC[i][19];
            ptx_fill  = VEC[i][16:12];
            nptx_fill = VEC[i][11:7];
            inep_fill = VEC[i][6:2];
            bus_write(1'b1, {23'b0, VEC[i][18], VEC[i][17], 6'b0, 1'b1});
            #1;
            check($sformatf("R5 ptx vec%0d", i), {31'b0, ptx_empty}, {31'b0, VEC[i][1]});
            check($sformatf("R6 np vec%0d", i),  {31'b0, np_empty},  {31'b0, VEC[i][0]});
            settle(1);
            check($sformatf("R7 irq vec%0d", i), {31'b0, irq_out}, {31'b0, VEC[i][1] | VEC[i][0]});
        end

        // R8: reserved bits
        bus_write(1'b1, 32'hFFFF_FFFF);
        bus_read(1'b1, d); check("R8 config bits", d, 32'h0000_0181);
        // R9: status write leaves config alone
        bus_write(1'b0, 32'hFFFF_FFFF);
        bus_read(1'b1, d); check("R9 config kept", d, 32'h0000_0181);
        bus_read(1'b0, d); check("R8 status sw set blocked", d, 32'h0);

        // Quiet FIFOs, global enable only
        host_mode = 1'b1;
        ptx_fill = 5'd16; nptx_fill = 5'd16; inep_fill = 5'd16;
        bus_write(1'b1, 32'h1);

        // R2: rising edge does not set
        vbus_valid = 1'b1;
        settle(5);
        bus_read(1'b0, d); check("R2 rising no set", d, 32'h0);
        // R2: falling edge latency
        vbus_valid = 1'b0;
        settle(1); bus_read(1'b0, d); check("R2 edge1", d, 32'h0);
        settle(1); bus_read(1'b0, d); check("R2 edge2", d, 32'h0);
        check("R7 irq before", {31'b0, irq_out}, 32'h0);
        settle(1); bus_read(1'b0, d); check("R2 edge3 set", d, 32'h4);
        settle(1); check("R7 irq sess", {31'b0, irq_out}, 32'h1);

        // R3: write 0 no effect, write 1 clears, write 1 cannot set
        bus_write(1'b0, 32'hFFFF_FFFB);
        bus_read(1'b0, d); check("R3 write0 hold", d, 32'h4);
        bus_write(1'b0, 32'h4);
        bus_read(1'b0, d); check("R3 clear", d, 32'h0);
        settle(1); check("R7 irq cleared", {31'b0, irq_out}, 32'h0);
        bus_write(1'b0, 32'h4);
        bus_read(1'b0, d); check("R3 no sw set", d, 32'h0);

        // R2 in device mode
        host_mode = 1'b0;
        vbus_valid = 1'b1; settle(5);
        vbus_valid = 1'b0; settle(3);
        bus_read(1'b0, d); check("R2 device set", d, 32'h4);
        bus_write(1'b0, 32'h4);

        // R4: set and clear in the same cycle
        vbus_valid = 1'b1; settle(5);
        vbus_valid = 1'b0;
        settle(2);
        bus_write(1'b0, 32'h4);
        bus_read(1'b0, d); check("R4 set wins", d, 32'h4);
        bus_write(1'b0, 32'h4);
        bus_read(1'b0, d); check("R4 later clear", d, 32'h0);

        // R7: mask blocks a pending session-end
        vbus_valid = 1'b1; settle(5);
        vbus_valid = 1'b0; settle(3);
        bus_write(1'b1, 32'h0);
        settle(2);
        check("R7 masked", {31'b0, irq_out}, 32'h0);
        bus_write(1'b1, 32'h1);
        settle(1);
        check("R7 unmasked", {31'b0, irq_out}, 32'h1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule